// File: doc/BRIEF.md
# Inter-Processor Doorbell Interrupt Hub

This block lets a fixed set of processor agents interrupt one another. Each agent has its own small register bank. The bank is reached over one shared, single-cycle bus by giving an agent index and a word index. Each agent is identified by its own bit position: agent `i` always uses bit `i` in every vector register.

A sender rings one or more peers by writing a bit vector to its trigger word. Each addressed peer then records a pending notification from that sender. The peer raises its interrupt line if that source is unmasked. The sender can watch its observation word to see whether each peer has taken the notification yet. When the receiver clears the status bit, the sender's observation bit drops in the same clock.

Masking is changed only through separate set-style and clear-style words, so two pieces of software never need a read-modify-write. Agents can be declared secure. A bank marked that way refuses accesses marked non-secure and reports an error for them.

Top module: `ipi_hub`

## Requirements
- R1: A permitted write of vector V to word 0 (trigger) of agent L makes a notification from L pending at every agent R for which V[R]=1. It appears as bit L of R's status word (word 4) in the next cycle.
- R2: Bit R of agent L's observation word (word 1) reads 1 exactly while a notification from L to R is pending.
- R3: The status word is write-one-to-clear. Writing V to agent R's word 4 clears bit L for every V[L]=1, which also clears bit R of L's observation word. Zero bits change nothing. A trigger and an acknowledge of the same pair in one cycle leave the notification pending.
- R4: Word 5 (mask, 1 = masked) is read-only. Writing V to word 6 unmasks every source with V[i]=1. Writing V to word 7 masks every source with V[i]=1. Zero bits leave the mask unchanged.
- R5: `irq[R]` is 1 exactly when agent R has a status bit that is set and unmasked.
- R6: After reset every source is masked, all status and observation bits are 0 and every `irq` is 0.
- R7: `bus_rdata` is 0 except during a permitted read of words 1, 4 or 5. The following reads return 0 and writes to them change nothing:
  - the trigger word (write-only);
  - words 2 and 3;
  - any agent index of N or above.
  Writes to the observation and mask words are ignored.
- R8: An access with `bus_secure`=0 to an agent whose bit in `SECURE_AGENTS` is set changes no state, returns 0 and drives `bus_err`=1 in the same cycle. `bus_err` is 0 otherwise.
- R9: The open sequence is a write to word 7, then a write to word 4, both with the peer's bit. It leaves that peer's status bit clear and its interrupt source masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_secure | input | 1 | Access carries the secure attribute |
| bus_agent | input | IDX_W | Agent bank index |
| bus_word | input | 3 | Word index within the bank (byte offset / 4) |
| bus_wdata | input | N | Write vector, one bit per agent |
| bus_rdata | output | N | Read vector, valid in the access cycle |
| bus_err | output | 1 | Access refused by the secure check |
| irq | output | N | One interrupt line per agent |

## Verification
The hardest state to reach is a fan-out that is only partly acknowledged. In this state the sender's observation word shows some peers still pending while others have cleared. Some of those peers are masked and some are not.

Directed writes first ring two peers at once, unmask only one of them, and acknowledge one. Long random traffic then mixes triggers, acknowledges, mask changes, refused non-secure accesses and out-of-range indices. A behavioural model is compared against every output on every cycle.

// File: rtl/ipi_pkg.sv
// Shared definitions for the doorbell hub: the word map of one agent bank.
package ipi_pkg;
    typedef enum logic [2:0] {
        W_TRIG = 3'd0,
        W_OBS  = 3'd1,
        W_RSV2 = 3'd2,
        W_RSV3 = 3'd3,
        W_STAT = 3'd4,
        W_MASK = 3'd5,
        W_ENA  = 3'd6,
        W_DIS  = 3'd7
    } ipi_word_e;
endpackage

// File: rtl/ipi_decode.sv
// Access decoder. Turns one bus access into one-hot per-agent write strobes
// and a read select, and applies the per-agent secure check.
// Assumes at most one access per cycle; agent indices >= N select nothing.
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int N = 4,
    parameter logic [N-1:0] SECURE_AGENTS = '0,
    parameter int IDX_W = 3
) (
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic             bus_secure,
    input  logic [IDX_W-1:0] bus_agent,
    input  logic [2:0]       bus_word,
    output logic [N-1:0]     wr_trig,
    output logic [N-1:0]     wr_ack,
    output logic [N-1:0]     wr_ena,
    output logic [N-1:0]     wr_dis,
    output logic [N-1:0]     rd_sel,
    output logic             blocked
);
    logic [N-1:0] hit;
    logic [N-1:0] ok;
    ipi_word_e    word;

    // Select the addressed bank and refuse non-secure access to secure banks.
    always_comb begin
        word = ipi_word_e'(bus_word);
        for (int i = 0; i < N; i++) begin
            hit[i] = bus_valid && (bus_agent == IDX_W'(i));
        end
        blocked = |(hit & SECURE_AGENTS & ~{N{bus_secure}});
        ok      = blocked ? '0 : hit;
        wr_trig = ok & {N{bus_write && (word == W_TRIG)}};
        wr_ack  = ok & {N{bus_write && (word == W_STAT)}};
        wr_ena  = ok & {N{bus_write && (word == W_ENA)}};
        wr_dis  = ok & {N{bus_write && (word == W_DIS)}};
        rd_sel  = ok & {N{!bus_write}};
    end
endmodule

// File: rtl/ipi_pend_matrix.sv
// Pending-notification matrix. Row r holds agent r's status word; the same
// bits read column-wise form each sender's observation word, so an
// acknowledge at the receiver clears the sender's view in the same clock.
// Assumes one-hot wr_trig and wr_ack (a single bus port).
module ipi_pend_matrix #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] wr_trig,
    input  logic [N-1:0] wr_ack,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] status [N],
    output logic [N-1:0] obs    [N]
);
    logic [N*N-1:0] pend_flat;

    for (genvar r = 0; r < N; r++) begin : g_row
        logic [N-1:0] set_v;
        logic [N-1:0] clr_v;
        assign set_v = wr_trig & {N{wdata[r]}};
        assign clr_v = wr_ack[r] ? wdata : '0;

        // Update row r: acknowledges clear, triggers set and take priority.
        always_ff @(posedge clk) begin
            if (!rst_n) status[r] <= '0;
            else        status[r] <= (status[r] & ~clr_v) | set_v;
        end
        assign pend_flat[r*N +: N] = status[r];

        for (genvar l = 0; l < N; l++) begin : g_col
            // R1
            trig_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_trig[l] && wdata[r]) |=> status[r][l]);
            // R3
            ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_ack[r] && wdata[l] && !(wr_trig[l] && wdata[r])) |=> !status[r][l]);
        end
    end

    // Transpose rows into per-sender observation words.
    always_comb begin
        for (int l = 0; l < N; l++) begin
            for (int r = 0; r < N; r++) begin
                obs[l][r] = status[r][l];
            end
        end
    end

    // R2
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_trig == '0 && wr_ack == '0) |=> $stable(pend_flat));
endmodule

// File: rtl/ipi_mask_bank.sv
// Per-agent interrupt mask (1 = masked) changed only by set-style and
// clear-style strobes. Assumes wr_ena and wr_dis are never both set for
// the same agent.
module ipi_mask_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] wr_ena,
    input  logic [N-1:0] wr_dis,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask [N]
);
    logic [N*N-1:0] mask_flat;

    for (genvar a = 0; a < N; a++) begin : g_agent
        // Hold agent a's mask; disable sets bits, enable clears bits.
        always_ff @(posedge clk) begin
            if (!rst_n)         mask[a] <= '1;
            else if (wr_dis[a]) mask[a] <= mask[a] | wdata;
            else if (wr_ena[a]) mask[a] <= mask[a] & ~wdata;
        end
        assign mask_flat[a*N +: N] = mask[a];

        // R4
        ena_unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_ena[a] |=> ((mask[a] & $past(wdata)) == '0));
    end

    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ena == '0 && wr_dis == '0) |=> $stable(mask_flat));
endmodule

// File: rtl/ipi_hub.sv
// Doorbell interrupt hub top. Decodes the shared register bus, keeps the
// pending matrix and masks, returns read data in the access cycle and
// drives one interrupt per agent. Assumes one access per cycle.
module ipi_hub
    import ipi_pkg::*;
#(
    parameter int N = 4,
    parameter logic [N-1:0] SECURE_AGENTS = 4'b1000,
    localparam int IDX_W = $clog2(N) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic             bus_secure,
    input  logic [IDX_W-1:0] bus_agent,
    input  logic [2:0]       bus_word,
    input  logic [N-1:0]     bus_wdata,
    output logic [N-1:0]     bus_rdata,
    output logic             bus_err,
    output logic [N-1:0]     irq
);
    logic [N-1:0] wr_trig, wr_ack, wr_ena, wr_dis, rd_sel;
    logic [N-1:0] status [N];
    logic [N-1:0] obs    [N];
    logic [N-1:0] mask   [N];

    ipi_decode #(.N(N), .SECURE_AGENTS(SECURE_AGENTS), .IDX_W(IDX_W)) u_dec (
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_secure(bus_secure),
        .bus_agent(bus_agent), .bus_word(bus_word),
        .wr_trig(wr_trig), .wr_ack(wr_ack), .wr_ena(wr_ena), .wr_dis(wr_dis),
        .rd_sel(rd_sel), .blocked(bus_err)
    );

    ipi_pend_matrix #(.N(N)) u_pend (
        .clk(clk), .rst_n(rst_n), .wr_trig(wr_trig), .wr_ack(wr_ack),
        .wdata(bus_wdata), .status(status), .obs(obs)
    );

    ipi_mask_bank #(.N(N)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_ena(wr_ena), .wr_dis(wr_dis),
        .wdata(bus_wdata), .mask(mask)
    );

    // Interrupt per agent: any set status bit that is not masked.
    for (genvar i = 0; i < N; i++) begin : g_irq
        assign irq[i] = |(status[i] & ~mask[i]);
    end

    // Read mux for the selected bank; everything else reads zero.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_sel[i]) begin
                case (ipi_word_e'(bus_word))
                    W_OBS:   bus_rdata = obs[i];
                    W_STAT:  bus_rdata = status[i];
                    W_MASK:  bus_rdata = mask[i];
                    default: bus_rdata = '0;
                endcase
            end
        end
    end

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0 && bus_valid));
    // R6
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (irq == '0));
endmodule

// File: tb/sim_ipi_hub.sv
// Bench for ipi_hub: behavioural reference model compared on every clock.
module sim_ipi_hub;
    localparam int N = 4;
    localparam logic [N-1:0] SEC = 4'b1000;

    logic clk = 0, rst_n = 0;
    logic bus_valid = 0, bus_write = 0, bus_secure = 1;
    logic [2:0] bus_agent = 0;
    logic [2:0] bus_word = 0;
    logic [N-1:0] bus_wdata = 0;
    logic [N-1:0] bus_rdata;
    logic bus_err;
    logic [N-1:0] irq;

    int checks = 0, fails = 0;
    bit [N-1:0] m_pend [N];   // m_pend[r][l]: notification from l pending at r
    bit [N-1:0] m_mask [N];

    always #10 clk = ~clk;

    ipi_hub #(.N(N), .SECURE_AGENTS(SEC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_secure(bus_secure), .bus_agent(bus_agent), .bus_word(bus_word),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_blocked();
        return bus_valid && bus_agent < N && SEC[bus_agent] && !bus_secure;
    endfunction

    function automatic bit m_ok();
        return bus_valid && bus_agent < N && !m_blocked();
    endfunction

    // Reference model update at the clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_pend[i] = '0; m_mask[i] = '1; end
        end else if (m_ok() && bus_write) begin
            case (bus_word)
                3'd0: for (int r = 0; r < N; r++) if (bus_wdata[r]) m_pend[r][bus_agent] = 1;
                3'd4: for (int l = 0; l < N; l++) if (bus_wdata[l]) m_pend[bus_agent][l] = 0;
                3'd6: m_mask[bus_agent] = m_mask[bus_agent] & ~bus_wdata;
                3'd7: m_mask[bus_agent] = m_mask[bus_agent] | bus_wdata;
                default: ;
            endcase
        end
    end

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        logic [N-1:0] er, ei;
        string tag;
        er = '0; tag = "R7";
        if (m_ok() && !bus_write) begin
            case (bus_word)
                3'd1: begin tag = "R2"; for (int r = 0; r < N; r++) er[r] = m_pend[r][bus_agent]; end
                3'd4: begin tag = "R1/R3"; er = m_pend[bus_agent]; end
                3'd5: begin tag = "R4"; er = m_mask[bus_agent]; end
                default: ;
            endcase
        end
        if (m_blocked()) tag = "R8";
        chk(tag, bus_rdata, er);
        chk("R8", bus_err, m_blocked());
        for (int i = 0; i < N; i++) ei[i] = |(m_pend[i] & ~m_mask[i]);
        chk("R5", irq, ei);
    end

    task automatic acc(input bit w, input int a, input int wd, input int d, input bit s = 1);
        @(posedge clk); #1;
        bus_valid = 1; bus_write = w; bus_agent = 3'(a); bus_word = 3'(wd);
        bus_wdata = N'(d); bus_secure = s;
        @(posedge clk); #1;
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd_expect(string tag, int a, int wd, int exp);
        @(posedge clk); #1;
        bus_valid = 1; bus_write = 0; bus_agent = 3'(a); bus_word = 3'(wd); bus_secure = 1;
        @(negedge clk);
        chk(tag, bus_rdata, exp);
        @(posedge clk); #1;
        bus_valid = 0;
    endtask

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R6: masks all set, nothing pending after reset
        @(negedge clk);
        chk("R6", irq, 0);
        rd_expect("R6", 1, 5, 4'hF);
        rd_expect("R6", 0, 1, 0);
        // R1: agent 0 rings agents 1 and 2; only 1 is unmasked
        acc(1, 1, 6, 4'b0001);
        acc(1, 0, 0, 4'b0110);
        rd_expect("R2", 0, 1, 4'b0110);
        rd_expect("R1", 2, 4, 4'b0001);
        @(negedge clk); chk("R5", irq, 4'b0010);
        // R3: agent 1 acknowledges; sender view drops bit 1
        acc(1, 1, 4, 4'b0001);
        rd_expect("R3", 0, 1, 4'b0100);
        // R7: writes to observation and mask words ignored, trigger reads zero
        acc(1, 0, 1, 4'hF);
        acc(1, 2, 5, 4'h0);
        rd_expect("R7", 2, 5, 4'hF);
        rd_expect("R7", 0, 0, 0);
        acc(1, 0, 2, 4'hF);
        rd_expect("R7", 0, 3, 0);
        acc(1, 5, 0, 4'hF);
        rd_expect("R7", 5, 4, 0);
        rd_expect("R7", 1, 4, 4'h0);
        // R8: non-secure write to secure agent 3 is refused
        acc(1, 3, 6, 4'hF, 0);
        rd_expect("R8", 3, 5, 4'hF);
        // R9: open sequence at agent 2 for peer 0
        acc(1, 2, 7, 4'b0001);
        acc(1, 2, 4, 4'b0001);
        rd_expect("R9", 2, 4, 0);
        rd_expect("R9", 2, 5, 4'hF);
        // Random traffic, checked each cycle by the model
        for (int k = 0; k < 4000; k++) begin
            @(posedge clk); #1;
            bus_valid  = ($urandom_range(0, 3) != 0);
            bus_write  = $urandom_range(0, 1);
            bus_agent  = 3'($urandom_range(0, 5));
            bus_word   = 3'($urandom_range(0, 7));
            bus_wdata  = N'($urandom);
            bus_secure = ($urandom_range(0, 3) != 0);
        end
        @(posedge clk); #1 bus_valid = 0;
        repeat (2) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule